// File: doc/BRIEF.md
# Slot-Scheduled Video Write FIFO

This block buffers host writes bound for video memory in a four-entry, 16-bit ring. Entries are not drained whenever memory is free. A master-cycle counter runs across each 3420-cycle scanline, and the block retires an entry only when that counter lands on one of the access positions of the current width mode. The narrow mode has 16 such positions per line and the wide mode has 18. They are spaced irregularly. When the host marks its accesses as byte-wide, each entry uses up two access positions before it retires.

The host pushes a word together with its byte-access flag. If it pushes while the ring is full, the block raises a wait output. The host keeps the word and the push asserted until an access position frees an entry, and the word is accepted in that same cycle. Toward memory the block produces a one-cycle write strobe with the head entry. The strobe only ever appears on an access-position cycle. The full and empty flags are exported as separate outputs. The line position is exported too, so that neighbouring logic can align to it.

Top module: `vwr_slot_fifo`

## Requirements
- R1: After reset, empty is 1, full, wait_o and mem_wr are 0, line_pos is 0 and the narrow table is active.
- R2: line_pos advances by one per clock from 0 to 3419 and then returns to 0.
- R3: In narrow mode (wide_mode=0) an entry can retire only when line_pos is one of 230, 510, 810, 970, 1130, 1450, 1610, 1770, 2090, 2250, 2410, 2730, 2890, 3050, 3350, 3370.
- R4: In wide mode (wide_mode=1) an entry can retire only when line_pos is one of 352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972, 2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364, 3380.
- R5: Entries appear on mem_wdata in the order they were pushed, with mem_wr high for exactly the access-position cycle on which the entry retires. Nothing is written while the ring is empty.
- R6: full is 1 while four entries are held and empty is 1 while none are held. A push into a full ring raises wait_o and is not taken. If an entry retires in that cycle, the push is taken in that same cycle instead.
- R7: With byte_mode=1, an entry retires on the second access position it meets, not on the first.
- R8: While the ring is empty, passing access positions are not counted toward a byte-mode pair. An entry pushed after such a position still needs two further positions.
- R9: A change of wide_mode takes effect from the clock edge that samples it. Access positions after that edge follow the newly selected table.
- R10: mem_wr is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per master cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects the 18-position table, 0 the 16-position table |
| byte_mode | input | 1 | 1 makes each entry consume two access positions |
| push | input | 1 | Host offers push_data this cycle |
| push_data | input | 16 | Word from the host |
| wait_o | output | 1 | Push refused this cycle; hold the word |
| full | output | 1 | Four entries held |
| empty | output | 1 | No entry held |
| line_pos | output | 12 | Master-cycle position within the scanline |
| mem_wr | output | 1 | Write strobe toward video memory |
| mem_wdata | output | 16 | Entry being written |

## Verification
The bench builds the block with its default parameters: a 16-bit width, a depth of four and a 3420-cycle line. At that size, one line of continuous pushing drains through every access position of a table, and a ring of four fills within four cycles, so the wait path can be reached with a single extra push. Directed pushes placed just before or after chosen positions exercise the byte-mode pairing, the pairing restart on an empty ring, and mode changes in both directions within a line.

// File: rtl/vwr_slot_fifo.sv
module vwr_slot_fifo #(
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int LINE_CYCLES = 3420,
  localparam int PW = $clog2(LINE_CYCLES),
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          byte_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          wait_o,
  output logic          full,
  output logic          empty,
  output logic [PW-1:0] line_pos,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata
);
  localparam int NN = 16;
  localparam int NW = 18;
  localparam int N_OFF [NN] = '{230, 510, 810, 970, 1130, 1450, 1610, 1770,
                                2090, 2250, 2410, 2730, 2890, 3050, 3350, 3370};
  localparam int W_OFF [NW] = '{352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972,
                                2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364, 3380};

  logic [PW-1:0] pos_q;
  logic          wide_q;
  logic          half_q;
  logic [CW-1:0] count_q;
  logic [AW-1:0] rd_q, wr_q;
  logic [DW-1:0] ring [DEPTH];
  logic          hit_n, hit_w, slot_hit, busy, retire, accept;

  always_comb begin
    hit_n = 1'b0;
    for (int i = 0; i < NN; i++)
      if (int'(pos_q) == N_OFF[i]) hit_n = 1'b1;
  end

  always_comb begin
    hit_w = 1'b0;
    for (int i = 0; i < NW; i++)
      if (int'(pos_q) == W_OFF[i]) hit_w = 1'b1;
  end

  assign slot_hit  = wide_q ? hit_w : hit_n;
  assign busy      = (count_q != '0);
  assign retire    = slot_hit && busy && (!byte_mode || half_q);
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = !busy;
  assign wait_o    = push && full && !retire;
  assign accept    = push && !wait_o;
  assign mem_wr    = retire;
  assign mem_wdata = ring[rd_q];
  assign line_pos  = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      wide_q  <= 1'b0;
      half_q  <= 1'b0;
      count_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      pos_q  <= (pos_q == PW'(LINE_CYCLES - 1)) ? '0 : pos_q + PW'(1);
      wide_q <= wide_mode;
      if (!busy || !byte_mode)
        half_q <= 1'b0;
      else if (slot_hit)
        half_q <= !half_q;
      if (accept) wr_q <= wr_q + AW'(1);
      if (retire) rd_q <= rd_q + AW'(1);
      count_q <= count_q + CW'(accept) - CW'(retire);
    end
  end

  always_ff @(posedge clk)
    if (accept) ring[wr_q] <= push_data;
endmodule

// File: rtl/vwr_slot_fifo_chk.sv
module vwr_slot_fifo_chk #(
  parameter int LINE_CYCLES = 3420,
  localparam int PW = $clog2(LINE_CYCLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          wait_o,
  input logic          full,
  input logic          empty,
  input logic [PW-1:0] line_pos,
  input logic          mem_wr
);
  localparam logic [PW-1:0] LAST = PW'(LINE_CYCLES - 1);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_pos == LAST |=> line_pos == '0);
  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_pos != LAST |=> line_pos == $past(line_pos) + PW'(1));
  p_no_wr_empty_r5: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !mem_wr);
  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push |=> empty);
  p_wait_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> full && push && !mem_wr);
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && !mem_wr |=> full);
  p_wr_spaced_r10: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr);
endmodule

bind vwr_slot_fifo vwr_slot_fifo_chk #(.LINE_CYCLES(LINE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .wait_o(wait_o), .full(full),
  .empty(empty), .line_pos(line_pos), .mem_wr(mem_wr)
);

// File: tb/test_vwr_slot_fifo.sv
module test_vwr_slot_fifo;
  logic clk = 1'b0, rst_n = 1'b0, wide_mode = 1'b0, byte_mode = 1'b0, push = 1'b0;
  logic [15:0] push_data = '0;
  logic wait_o, full, empty, mem_wr;
  logic [11:0] line_pos;
  logic [15:0] mem_wdata;

  int n_chk = 0, n_bad = 0, wr_count = 0;
  int last_pos;
  logic [15:0] exp_q[$];
  int pos_q[$];
  logic [15:0] next_word = 16'h1000;

  int NARROW [16] = '{230, 510, 810, 970, 1130, 1450, 1610, 1770,
                      2090, 2250, 2410, 2730, 2890, 3050, 3350, 3370};
  int WIDE [18] = '{352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972,
                    2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364, 3380};

  vwr_slot_fifo i_vwr_slot_fifo (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .byte_mode(byte_mode),
    .push(push), .push_data(push_data), .wait_o(wait_o), .full(full), .empty(empty),
    .line_pos(line_pos), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && mem_wr) begin
      wr_count++;
      last_pos = int'(line_pos);
      pos_q.push_back(int'(line_pos));
      if (exp_q.size() == 0) check(1'b0, "R5 write with no pending entry", 1, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(mem_wdata == e, "R5 order", int'(mem_wdata), int'(e));
      end
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (int'(line_pos) != p);
  endtask

  task automatic push_word(output bit saw_wait);
    bit w;
    saw_wait = 1'b0;
    push = 1'b1;
    push_data = next_word;
    do begin
      #1;
      w = wait_o;
      if (w) saw_wait = 1'b1;
      @(negedge clk);
    end while (w);
    exp_q.push_back(next_word);
    next_word = next_word + 16'h0101;
    push = 1'b0;
  endtask

  task automatic drain;
    while (!empty) @(negedge clk);
  endtask

  task automatic expect_wr(input int p, input string req);
    int c;
    c = wr_count;
    while (wr_count == c) @(negedge clk);
    check(last_pos == p, req, last_pos, p);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit sw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(empty == 1'b1, "R1 empty", int'(empty), 1);
    check(full == 1'b0, "R1 full", int'(full), 0);
    check(wait_o == 1'b0, "R1 wait", int'(wait_o), 0);
    check(mem_wr == 1'b0, "R1 mem_wr", int'(mem_wr), 0);
    check(line_pos == 12'd0, "R1 line_pos", int'(line_pos), 0);

    wait_pos(3419);
    @(negedge clk);
    check(line_pos == 12'd0, "R2 wrap", int'(line_pos), 0);

    // R6: fill, then push into a full ring
    wait_pos(10);
    for (int i = 0; i < 4; i++) push_word(sw);
    #2;
    check(full == 1'b1, "R6 full after four", int'(full), 1);
    check(empty == 1'b0, "R6 not empty", int'(empty), 0);
    pos_q.delete();
    push_word(sw);
    check(sw == 1'b1, "R6 wait on full push", int'(sw), 1);
    check(pos_q.size() == 1 && pos_q[0] == 230, "R6 push taken on first slot",
          pos_q.size() ? pos_q[0] : -1, 230);
    drain();

    // R3: a full line through the narrow table
    wait_pos(5);
    pos_q.delete();
    for (int i = 0; i < 16; i++) push_word(sw);
    drain();
    check(pos_q.size() == 16, "R3 narrow slot count", pos_q.size(), 16);
    for (int i = 0; i < 16 && i < pos_q.size(); i++)
      check(pos_q[i] == NARROW[i], "R3 narrow slot position", pos_q[i], NARROW[i]);

    // R4: wide table
    wait_pos(3400);
    wide_mode = 1'b1;
    wait_pos(5);
    pos_q.delete();
    for (int i = 0; i < 18; i++) push_word(sw);
    drain();
    check(pos_q.size() == 18, "R4 wide slot count", pos_q.size(), 18);
    for (int i = 0; i < 18 && i < pos_q.size(); i++)
      check(pos_q[i] == WIDE[i], "R4 wide slot position", pos_q[i], WIDE[i]);

    // R7: byte mode uses two slots per entry
    wait_pos(3400);
    wide_mode = 1'b0;
    byte_mode = 1'b1;
    wait_pos(50);
    pos_q.delete();
    push_word(sw);
    push_word(sw);
    drain();
    check(pos_q.size() == 2, "R7 byte write count", pos_q.size(), 2);
    if (pos_q.size() == 2) begin
      check(pos_q[0] == 510, "R7 byte first retire", pos_q[0], 510);
      check(pos_q[1] == 970, "R7 byte second retire", pos_q[1], 970);
    end

    // R8: slot passed while empty does not count
    wait_pos(3400);
    wait_pos(300);
    push_word(sw);
    expect_wr(810, "R8 empty resync");
    byte_mode = 1'b0;

    // R9: mode change mid-line, both directions
    wait_pos(3400);
    wait_pos(1000);
    wide_mode = 1'b1;
    push_word(sw);
    expect_wr(1076, "R9 narrow to wide");
    wait_pos(1100);
    wide_mode = 1'b0;
    push_word(sw);
    expect_wr(1130, "R9 wide to narrow");

    // R10: strobe spacing on the adjacent narrow pair near line end
    wait_pos(3300);
    pos_q.delete();
    push_word(sw);
    push_word(sw);
    drain();
    check(pos_q.size() == 2 && pos_q[0] == 3350 && pos_q[1] == 3370,
          "R10 single-cycle strobes at late slots", pos_q.size() ? pos_q[0] : -1, 3350);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all entries written", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule